// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit CPU core and the memories and ports of a small handheld console. It takes a 16-bit CPU address and sorts it into one of the console's address windows: fixed and switchable cartridge ROM, video RAM, cartridge RAM, fixed and switchable work RAM with its mirror, sprite attribute RAM, a dead hole, I/O ports, a small high-speed scratch RAM and the interrupt-enable port. It returns the byte a read should see and raises one write strobe for the target of a write. The ROM, video RAM, cartridge RAM, work RAM array, sprite RAM, I/O ports and interrupt-enable port sit outside the block and are reached through plain data and strobe pins. The scratch RAM and the work-RAM bank register sit inside.

Two conditions close windows. The video mode closes video RAM while the picture is being fetched (mode 3) and closes sprite RAM in modes 2 and 3. A running sprite copy closes sprite RAM entirely and also closes every window on the same bus as the copy's source. Bus ownership is looked up per 8 KB slice, and the lookup differs between the monochrome and the colour console. The console type is taken from a pin once, at the first clock edge after reset ends.

Top module: `memmap_decoder`

## Requirements
- R1: A write with `wr_en` high raises at most one external strobe, bit order {rom, vram, xram, wram, oam, io, ie}: 0x0000-0x7FFF rom, 0x8000-0x9FFF vram, 0xA000-0xBFFF xram, 0xC000-0xFDFF wram, 0xFE00-0xFE9F oam, 0xFF00-0xFF7F except 0xFF70 io, 0xFFFF ie. Reads of an open window return that window's data input.
- R2: While `video_mode` is 3, reads of 0x8000-0x9FFF return 0xFF and raise no `vram_we`. In modes 0 to 2 video RAM is open.
- R3: Sprite RAM 0xFE00-0xFE9F is open only in video modes 0 and 1. In modes 2 and 3 reads return 0xFF and `oam_we` stays low.
- R4: A write to 0xFF70 stores the low 3 data bits in the bank register. Reading 0xFF70 returns 0xF8 OR the stored bits. The bank in use is the stored value, or 1 when the stored value is 0. Switchable work RAM drives `wram_addr` = {bank, addr[11:0]}.
- R5: 0xC000-0xCFFF and 0xE000-0xEFFF use bank 0 (`wram_addr[14:12]` = 0). 0xD000-0xDFFF and 0xF000-0xFDFF use the switchable bank.
- R6: Slice ownership: 0x8000 slice is the video bus, 0xE000 slice is the CPU-internal bus, all other slices are the main bus. The one exception is the 0xC000 slice, which is a separate work-RAM bus on the colour console. `dma_src_top` gives the DMA source slice, i.e. source address bits 15:13.
- R7: While `dma_active` is high, an access is blocked if its slice's bus equals the source slice's bus and that bus is not CPU-internal. The range 0xFE00-0xFEFF is always blocked. Blocked reads return 0xFF and blocked writes raise no strobe.
- R8: 0xFEA0-0xFEFF reads return 0xFF and writes raise no strobe.
- R9: A read in 0x0000-0x7FFF at an address greater than or equal to `rom_size` returns 0xFF. Writes there still raise `rom_we`, because they are meant for the bank controller.
- R10: 0xFF80-0xFFFE is an internal 127-byte scratch RAM. Writes to it or to 0xFF70 raise no external strobe.
- R11: After reset the bank register reads 0xF8 (bank 1 in use). The console type is captured from `color_sel` once and later changes of that pin have no effect.
- R12: `rdata`, the strobes and `wram_addr` follow the inputs combinationally. Scratch RAM and bank register writes take effect at the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| color_sel | input | 1 | Console type, 1 = colour, captured after reset |
| addr | input | 16 | CPU address |
| wr_en | input | 1 | CPU write request |
| wdata | input | 8 | CPU write data |
| video_mode | input | 2 | Current video mode 0-3 |
| dma_active | input | 1 | Sprite copy in progress |
| dma_src_top | input | 3 | Bits 15:13 of the sprite copy source |
| rom_size | input | 17 | ROM size in bytes |
| rom_rdata | input | 8 | ROM read data |
| vram_rdata | input | 8 | Video RAM read data |
| xram_rdata | input | 8 | Cartridge RAM read data |
| wram_rdata | input | 8 | Work RAM read data |
| oam_rdata | input | 8 | Sprite RAM read data |
| io_rdata | input | 8 | I/O port read data |
| ie_rdata | input | 8 | Interrupt-enable read data |
| rdata | output | 8 | Read data to CPU |
| ext_addr | output | 14 | Low address bits for external targets |
| rom_switch | output | 1 | Access falls in the switchable ROM window |
| wram_addr | output | 15 | Banked work RAM address |
| rom_we | output | 1 | ROM window write (to bank controller) |
| vram_we | output | 1 | Video RAM write strobe |
| xram_we | output | 1 | Cartridge RAM write strobe |
| wram_we | output | 1 | Work RAM write strobe |
| oam_we | output | 1 | Sprite RAM write strobe |
| io_we | output | 1 | I/O port write strobe |
| ie_we | output | 1 | Interrupt-enable write strobe |

## Verification
Read data, strobes and the work-RAM address settle in the same cycle as the address. The bench drives inputs after a falling edge and samples them a step later, raising `wr_en` only between edges, so no state changes when the strobes are probed. Scratch RAM and bank writes show up after the next rising edge. The bench reads them back one cycle later and also reads once before that edge to confirm the old value still holds. The console type becomes valid on the third rising edge after `rst_n` rises (two synchroniser stages and one capture). The bench waits four edges before its first access.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  typedef enum logic [3:0] {
    RG_ROM0, RG_ROMX, RG_VRAM, RG_XRAM,
    RG_WRAM0, RG_WRAMX, RG_ECHO0, RG_ECHOX,
    RG_OAM, RG_VOID, RG_IO, RG_BANK,
    RG_HRAM, RG_IE
  } region_e;

  typedef enum logic [1:0] {
    BUS_CORE, BUS_MAIN, BUS_VID, BUS_WRK
  } bus_e;

  // Bus owning an 8 KB slice; the colour console splits work RAM off.
  function automatic bus_e slice_bus(input logic [2:0] slice, input logic colour);
    bus_e b;
    case (slice)
      3'd4:    b = BUS_VID;
      3'd6:    b = colour ? BUS_WRK : BUS_MAIN;
      3'd7:    b = BUS_CORE;
      default: b = BUS_MAIN;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/region_decode.sv
module region_decode
  import memmap_pkg::*;
#(
  parameter logic [15:0] BANK_REG_ADDR = 16'hFF70
) (
  input  logic [15:0] addr,
  output region_e     region
);

  always_comb begin
    if (!addr[15]) begin
      region = addr[14] ? RG_ROMX : RG_ROM0;
    end else begin
      case (addr[14:12])
        3'd0, 3'd1: region = RG_VRAM;
        3'd2, 3'd3: region = RG_XRAM;
        3'd4:       region = RG_WRAM0;
        3'd5:       region = RG_WRAMX;
        3'd6:       region = RG_ECHO0;
        default: begin
          if (addr < 16'hFE00)            region = RG_ECHOX;
          else if (addr < 16'hFEA0)       region = RG_OAM;
          else if (addr < 16'hFF00)       region = RG_VOID;
          else if (addr == BANK_REG_ADDR) region = RG_BANK;
          else if (addr < 16'hFF80)       region = RG_IO;
          else if (addr != 16'hFFFF)      region = RG_HRAM;
          else                            region = RG_IE;
        end
      endcase
    end
  end

endmodule

// File: rtl/dma_guard.sv
module dma_guard
  import memmap_pkg::*;
(
  input  logic [15:0] addr,
  input  logic        colour,
  input  logic        dma_active,
  input  logic [2:0]  dma_src_top,
  output logic        blocked
);

  bus_e src_bus;
  bus_e acc_bus;
  logic same_bus;
  logic sprite_page;

  always_comb begin
    src_bus     = slice_bus(dma_src_top, colour);
    acc_bus     = slice_bus(addr[15:13], colour);
    same_bus    = (src_bus != BUS_CORE) && (src_bus == acc_bus);
    sprite_page = (addr[15:8] == 8'hFE);
    blocked     = dma_active && (same_bus || sprite_page);
  end

endmodule

// File: rtl/wram_bank_reg.sv
module wram_bank_reg #(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BANK_W-1:0] wbits,
  output logic [BANK_W-1:0] raw,
  output logic [BANK_W-1:0] eff
);

  logic [BANK_W-1:0] raw_q;
  logic [BANK_W-1:0] raw_d;

  always_comb begin
    raw_d = we ? wbits : raw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  always_comb begin
    raw = raw_q;
    eff = (raw_q == '0) ? BANK_W'(1) : raw_q;
  end

endmodule

// File: rtl/hram_store.sv
module hram_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 127,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_comb begin
    rdata = mem[idx];
  end

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int          DATA_W        = 8,
  parameter int          BANK_W        = 3,
  parameter int          HRAM_DEPTH    = 127,
  parameter int          ROM_SIZE_W    = 17,
  parameter logic [15:0] BANK_REG_ADDR = 16'hFF70,
  localparam int         EXT_W         = 14,
  localparam int         WOFF_W        = 12,
  localparam int         WADDR_W       = BANK_W + WOFF_W,
  localparam int         HRAM_AW       = $clog2(HRAM_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  color_sel,
  input  logic [15:0]           addr,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [1:0]            video_mode,
  input  logic                  dma_active,
  input  logic [2:0]            dma_src_top,
  input  logic [ROM_SIZE_W-1:0] rom_size,
  input  logic [DATA_W-1:0]     rom_rdata,
  input  logic [DATA_W-1:0]     vram_rdata,
  input  logic [DATA_W-1:0]     xram_rdata,
  input  logic [DATA_W-1:0]     wram_rdata,
  input  logic [DATA_W-1:0]     oam_rdata,
  input  logic [DATA_W-1:0]     io_rdata,
  input  logic [DATA_W-1:0]     ie_rdata,
  output logic [DATA_W-1:0]     rdata,
  output logic [EXT_W-1:0]      ext_addr,
  output logic                  rom_switch,
  output logic [WADDR_W-1:0]    wram_addr,
  output logic                  rom_we,
  output logic                  vram_we,
  output logic                  xram_we,
  output logic                  wram_we,
  output logic                  oam_we,
  output logic                  io_we,
  output logic                  ie_we
);

  localparam logic [DATA_W-1:0] OPEN_BUS = '1;

  // Reset: asserted at once, released through two flops.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Console type: captured on the first edge out of reset, then frozen.
  logic lock_q, lock_d;
  logic model_q, model_d;

  always_comb begin
    lock_d  = 1'b1;
    model_d = lock_q ? model_q : color_sel;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lock_q  <= 1'b0;
      model_q <= 1'b0;
    end else begin
      lock_q  <= lock_d;
      model_q <= model_d;
    end
  end

  region_e region;
  logic    blocked;

  region_decode #(
    .BANK_REG_ADDR(BANK_REG_ADDR)
  ) u_decode (
    .addr   (addr),
    .region (region)
  );

  dma_guard u_guard (
    .addr        (addr),
    .colour      (model_q),
    .dma_active  (dma_active),
    .dma_src_top (dma_src_top),
    .blocked     (blocked)
  );

  logic              wr_ok;
  logic              bank_we;
  logic              hram_we;
  logic [BANK_W-1:0] bank_raw;
  logic [BANK_W-1:0] bank_eff;
  logic [DATA_W-1:0] hram_rd;

  assign wr_ok = wr_en && !blocked;

  wram_bank_reg #(
    .BANK_W(BANK_W)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (bank_we),
    .wbits (wdata[BANK_W-1:0]),
    .raw   (bank_raw),
    .eff   (bank_eff)
  );

  hram_store #(
    .DATA_W (DATA_W),
    .DEPTH  (HRAM_DEPTH)
  ) u_hram (
    .clk   (clk),
    .we    (hram_we),
    .idx   (addr[HRAM_AW-1:0]),
    .wdata (wdata),
    .rdata (hram_rd)
  );

  logic rom_beyond;
  logic vram_open;
  logic oam_open;

  always_comb begin
    rom_beyond = ({{(ROM_SIZE_W-16){1'b0}}, addr} >= rom_size);
    vram_open  = (video_mode != 2'd3);
    oam_open   = !video_mode[1];
  end

  // Read path
  always_comb begin
    rdata = OPEN_BUS;
    if (!blocked) begin
      case (region)
        RG_ROM0, RG_ROMX:                   rdata = rom_beyond ? OPEN_BUS : rom_rdata;
        RG_VRAM:                            rdata = vram_open ? vram_rdata : OPEN_BUS;
        RG_XRAM:                            rdata = xram_rdata;
        RG_WRAM0, RG_WRAMX,
        RG_ECHO0, RG_ECHOX:                 rdata = wram_rdata;
        RG_OAM:                             rdata = oam_open ? oam_rdata : OPEN_BUS;
        RG_IO:                              rdata = io_rdata;
        RG_BANK:                            rdata = {{(DATA_W-BANK_W){1'b1}}, bank_raw};
        RG_HRAM:                            rdata = hram_rd;
        RG_IE:                              rdata = ie_rdata;
        default:                            rdata = OPEN_BUS;
      endcase
    end
  end

  // Write strobes
  always_comb begin
    rom_we  = wr_ok && (region == RG_ROM0 || region == RG_ROMX);
    vram_we = wr_ok && (region == RG_VRAM) && vram_open;
    xram_we = wr_ok && (region == RG_XRAM);
    wram_we = wr_ok && (region == RG_WRAM0 || region == RG_WRAMX ||
                        region == RG_ECHO0 || region == RG_ECHOX);
    oam_we  = wr_ok && (region == RG_OAM) && oam_open;
    io_we   = wr_ok && (region == RG_IO);
    ie_we   = wr_ok && (region == RG_IE);
    bank_we = wr_ok && (region == RG_BANK);
    hram_we = wr_ok && (region == RG_HRAM);
  end

  // Addresses toward external targets
  always_comb begin
    ext_addr   = addr[EXT_W-1:0];
    rom_switch = (region == RG_ROMX);
    if (region == RG_WRAMX || region == RG_ECHOX)
      wram_addr = {bank_eff, addr[WOFF_W-1:0]};
    else
      wram_addr = {{BANK_W{1'b0}}, addr[WOFF_W-1:0]};
  end

endmodule

// File: rtl/memmap_chk.sv
module memmap_chk #(
  parameter int DATA_W  = 8,
  parameter int WADDR_W = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic [15:0]        addr,
  input logic [1:0]         video_mode,
  input logic               dma_active,
  input logic [DATA_W-1:0]  rdata,
  input logic [WADDR_W-1:0] wram_addr,
  input logic [6:0]         strobes,
  input logic               vram_we,
  input logic               oam_we
);

  logic in_vram, in_oam, in_void, in_wramx, in_echo0;

  always_comb begin
    in_vram  = (addr[15:13] == 3'b100);
    in_oam   = (addr >= 16'hFE00) && (addr < 16'hFEA0);
    in_void  = (addr >= 16'hFEA0) && (addr < 16'hFF00);
    in_wramx = (addr[15:12] == 4'hD);
    in_echo0 = (addr[15:12] == 4'hE);
  end

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  // R2
  vram_mode3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vram && video_mode == 2'd3) |-> (!vram_we && rdata == '1));

  // R3
  oam_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_oam && video_mode[1]) |-> (!oam_we && rdata == '1));

  // R7
  oam_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_oam && dma_active) |-> (!oam_we && rdata == '1));

  // R8
  void_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_void |-> (strobes == 7'd0 && rdata == '1));

  // R4
  bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wramx |-> (wram_addr[WADDR_W-1:12] != '0));

  // R5
  echo_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_echo0 |-> (wram_addr[WADDR_W-1:12] == '0));

endmodule

bind memmap_decoder memmap_chk #(
  .DATA_W  (DATA_W),
  .WADDR_W (WADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .addr       (addr),
  .video_mode (video_mode),
  .dma_active (dma_active),
  .rdata      (rdata),
  .wram_addr  (wram_addr),
  .strobes    ({rom_we, vram_we, xram_we, wram_we, oam_we, io_we, ie_we}),
  .vram_we    (vram_we),
  .oam_we     (oam_we)
);

// File: tb/memmap_decoder_test.sv
module memmap_decoder_test;

  localparam int CLK_P = 10;
  localparam int NV    = 30;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        color_sel;
  logic [15:0] addr;
  logic        wr_en;
  logic [7:0]  wdata;
  logic [1:0]  video_mode;
  logic        dma_active;
  logic [2:0]  dma_src_top;
  logic [16:0] rom_size;
  logic [7:0]  rdata;
  logic [13:0] ext_addr;
  logic        rom_switch;
  logic [14:0] wram_addr;
  logic        rom_we, vram_we, xram_we, wram_we, oam_we, io_we, ie_we;
  logic [6:0]  stb;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic cur_col;

  always #(CLK_P/2) clk = ~clk;

  memmap_decoder uut (
    .clk(clk), .rst_n(rst_n), .color_sel(color_sel), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .video_mode(video_mode),
    .dma_active(dma_active), .dma_src_top(dma_src_top), .rom_size(rom_size),
    .rom_rdata(8'hA1), .vram_rdata(8'hB2), .xram_rdata(8'hC3),
    .wram_rdata(8'hD4), .oam_rdata(8'hE5), .io_rdata(8'h96), .ie_rdata(8'h87),
    .rdata(rdata), .ext_addr(ext_addr), .rom_switch(rom_switch),
    .wram_addr(wram_addr), .rom_we(rom_we), .vram_we(vram_we),
    .xram_we(xram_we), .wram_we(wram_we), .oam_we(oam_we),
    .io_we(io_we), .ie_we(ie_we)
  );

  assign stb = {rom_we, vram_we, xram_we, wram_we, oam_we, io_we, ie_we};

  // Fields: req[41:38] col[37] mode[36:35] dma[34] src[33:31]
  //         addr[30:15] rdata[14:7] strobes[6:0]
  localparam logic [41:0] VEC [NV] = '{
    {4'd1, 1'b0, 2'd0, 1'b0, 3'd0, 16'h0150, 8'hA1, 7'h40}, // R1 rom0
    {4'd1, 1'b0, 2'd0, 1'b0, 3'd0, 16'h4000, 8'hA1, 7'h40}, // R1 romx
    {4'd1, 1'b0, 2'd0, 1'b0, 3'd0, 16'h8010, 8'hB2, 7'h20}, // R1 vram
    {4'd2, 1'b0, 2'd3, 1'b0, 3'd0, 16'h8010, 8'hFF, 7'h00}, // R2 mode 3
    {4'd2, 1'b0, 2'd2, 1'b0, 3'd0, 16'h9FFF, 8'hB2, 7'h20}, // R2 mode 2 open
    {4'd1, 1'b0, 2'd0, 1'b0, 3'd0, 16'hA123, 8'hC3, 7'h10}, // R1 xram
    {4'd1, 1'b0, 2'd0, 1'b0, 3'd0, 16'hC000, 8'hD4, 7'h08}, // R1 wram
    {4'd5, 1'b0, 2'd0, 1'b0, 3'd0, 16'hD800, 8'hD4, 7'h08}, // R5 wramx
    {4'd5, 1'b0, 2'd0, 1'b0, 3'd0, 16'hE100, 8'hD4, 7'h08}, // R5 echo
    {4'd3, 1'b0, 2'd1, 1'b0, 3'd0, 16'hFE00, 8'hE5, 7'h04}, // R3 mode 1 open
    {4'd3, 1'b0, 2'd2, 1'b0, 3'd0, 16'hFE9F, 8'hFF, 7'h00}, // R3 mode 2
    {4'd3, 1'b0, 2'd3, 1'b0, 3'd0, 16'hFE50, 8'hFF, 7'h00}, // R3 mode 3
    {4'd8, 1'b0, 2'd0, 1'b0, 3'd0, 16'hFEA0, 8'hFF, 7'h00}, // R8
    {4'd8, 1'b0, 2'd0, 1'b0, 3'd0, 16'hFEFF, 8'hFF, 7'h00}, // R8
    {4'd1, 1'b0, 2'd0, 1'b0, 3'd0, 16'hFF00, 8'h96, 7'h02}, // R1 io
    {4'd1, 1'b0, 2'd0, 1'b0, 3'd0, 16'hFFFF, 8'h87, 7'h01}, // R1 ie
    {4'd6, 1'b0, 2'd0, 1'b1, 3'd5, 16'hC010, 8'hFF, 7'h00}, // R6 mono C000 main
    {4'd7, 1'b0, 2'd0, 1'b1, 3'd5, 16'h0100, 8'hFF, 7'h00}, // R7
    {4'd7, 1'b0, 2'd0, 1'b1, 3'd5, 16'h8000, 8'hB2, 7'h20}, // R7 other bus
    {4'd7, 1'b0, 2'd0, 1'b1, 3'd5, 16'hFF00, 8'h96, 7'h02}, // R7 internal
    {4'd7, 1'b0, 2'd0, 1'b1, 3'd5, 16'hFE10, 8'hFF, 7'h00}, // R7 oam always
    {4'd7, 1'b0, 2'd0, 1'b1, 3'd4, 16'h8000, 8'hFF, 7'h00}, // R7 video src
    {4'd7, 1'b0, 2'd0, 1'b1, 3'd4, 16'hC000, 8'hD4, 7'h08}, // R7
    {4'd7, 1'b0, 2'd0, 1'b1, 3'd7, 16'hE000, 8'hD4, 7'h08}, // R7 cpu src
    {4'd7, 1'b0, 2'd0, 1'b1, 3'd7, 16'hFE00, 8'hFF, 7'h00}, // R7 oam always
    {4'd6, 1'b1, 2'd0, 1'b1, 3'd5, 16'hC010, 8'hD4, 7'h08}, // R6 colour split
    {4'd6, 1'b1, 2'd0, 1'b1, 3'd5, 16'h2000, 8'hFF, 7'h00}, // R6
    {4'd6, 1'b1, 2'd0, 1'b1, 3'd6, 16'hD000, 8'hFF, 7'h00}, // R6 wram bus
    {4'd6, 1'b1, 2'd0, 1'b1, 3'd6, 16'hA000, 8'hC3, 7'h10}, // R6
    {4'd1, 1'b1, 2'd0, 1'b0, 3'd0, 16'h7FFF, 8'hA1, 7'h40}  // R1
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic col);
    rst_n = 1'b0;
    color_sel = col;
    cur_col = col;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_cycle(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_at(input logic [15:0] a);
    addr = a;
    #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    addr = 16'h0000; wr_en = 1'b0; wdata = 8'h00; video_mode = 2'd0;
    dma_active = 1'b0; dma_src_top = 3'd0; rom_size = 17'h08000;
    do_reset(1'b0);

    // R11 reset state of bank register
    rd_at(16'hFF70); chk("R11", {8'h0, rdata}, 16'h00F8);
    rd_at(16'hD000); chk("R11", {1'b0, wram_addr}, 16'h1000);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[41:38], i);
      if (v[37] != cur_col) do_reset(v[37]);
      @(negedge clk);
      video_mode = v[36:35]; dma_active = v[34]; dma_src_top = v[33:31];
      addr = v[30:15]; wr_en = 1'b0;
      #1 chk(tag, {8'h0, rdata}, {8'h0, v[14:7]});
      wr_en = 1'b1;
      #1 chk(tag, {9'h0, stb}, {9'h0, v[6:0]});
      wr_en = 1'b0;
    end

    do_reset(1'b0);
    video_mode = 2'd0; dma_active = 1'b0;

    // R4 and R10: bank write, no external strobe
    @(negedge clk); addr = 16'hFF70; wdata = 8'h05; wr_en = 1'b1;
    #1 chk("R10", {9'h0, stb}, 16'h0000);
    @(negedge clk); wr_en = 1'b0;
    rd_at(16'hFF70); chk("R4", {8'h0, rdata}, 16'h00FD);
    rd_at(16'hD234); chk("R4", {1'b0, wram_addr}, 16'h5234);
    wr_cycle(16'hFF70, 8'h0F);
    rd_at(16'hFF70); chk("R4", {8'h0, rdata}, 16'h00FF);
    rd_at(16'hDFFF); chk("R4", {1'b0, wram_addr}, 16'h7FFF);
    wr_cycle(16'hFF70, 8'h08);
    rd_at(16'hFF70); chk("R4", {8'h0, rdata}, 16'h00F8);
    rd_at(16'hF100); chk("R5", {1'b0, wram_addr}, 16'h1100);
    rd_at(16'hE100); chk("R5", {1'b0, wram_addr}, 16'h0100);
    rd_at(16'hC100); chk("R5", {1'b0, wram_addr}, 16'h0100);

    // R10 and R12 scratch RAM
    wr_cycle(16'hFF80, 8'h5A);
    rd_at(16'hFF80); chk("R10", {8'h0, rdata}, 16'h005A);
    addr = 16'hFF80; wdata = 8'hA5; wr_en = 1'b1;
    #1 chk("R12", {8'h0, rdata}, 16'h005A);
    chk("R10", {9'h0, stb}, 16'h0000);
    @(negedge clk); wr_en = 1'b0;
    rd_at(16'hFF80); chk("R12", {8'h0, rdata}, 16'h00A5);
    wr_cycle(16'hFFFE, 8'h3C);
    rd_at(16'hFFFE); chk("R10", {8'h0, rdata}, 16'h003C);
    rd_at(16'hFF80); chk("R10", {8'h0, rdata}, 16'h00A5);

    // R9 ROM size limit
    rom_size = 17'h04000;
    rd_at(16'h3FFF); chk("R9", {8'h0, rdata}, 16'h00A1);
    rd_at(16'h4000); chk("R9", {8'h0, rdata}, 16'h00FF);
    rd_at(16'h7FFF); chk("R9", {8'h0, rdata}, 16'h00FF);
    wr_en = 1'b1;
    #1 chk("R9", {9'h0, stb}, 16'h0040);
    wr_en = 1'b0;
    rom_size = 17'h06000;
    rd_at(16'h5FFF); chk("R9", {8'h0, rdata}, 16'h00A1);
    rd_at(16'h6000); chk("R9", {8'h0, rdata}, 16'h00FF);
    rom_size = 17'h08000;

    // R11 console type frozen after capture
    @(negedge clk); color_sel = 1'b1;
    repeat (3) @(negedge clk);
    dma_active = 1'b1; dma_src_top = 3'd5;
    rd_at(16'hC010); chk("R11", {8'h0, rdata}, 16'h00FF);
    dma_active = 1'b0;
    rd_at(16'hC010); chk("R11", {8'h0, rdata}, 16'h00D4);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule